// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block shifts or rotates a byte, word or long operand by one or two bit positions and produces the shifted value together with fresh negative, zero, overflow and carry flags. It serves the integer datapath of a processor core. The decoder supplies the operand, the operand size, a three-bit operation code, a single select bit for a distance of two, and the current carry flag. The result and flags come back one clock later from output registers.

A distance of two is built as two chained single-bit steps. Carry, overflow and the bit that enters the vacated end therefore follow the last bit moved, and a rotate through carry passes the bit that leaves in the first step into the second.

Top module: `shr_unit`

## Requirements
- R1: The size code selects the operand width: 0 is byte (bits 7:0), 1 is word (bits 15:0), 2 and 3 are long (bits 31:0). Operand bits above the selected width have no effect, and result bits above it are zero.
- R2: When by_two_i is 0 the operand moves one position. When it is 1 the operand moves two positions, and the flags follow the second step.
- R3: Op 0 is a logical left shift. Zeros enter at bit 0. C is the last bit shifted out of the top: the original top bit for one step, or the bit just below it for two steps.
- R4: Op 1 is a logical right shift. Zeros enter at the top. C is the last bit shifted out of bit 0: original bit 0 for one step, or bit 1 for two steps.
- R5: Op 3 is an arithmetic right shift. The original sign bit fills every vacated top position, and C is the last bit shifted out of bit 0.
- R6: Op 2 is an arithmetic left shift. Its result and C are the same as for op 0. V is 1 when any bit that passes into the sign position differs from the original sign bit.
- R7: V is 0 after every operation other than op 2.
- R8: Op 4 rotates left and op 5 rotates right. The bit that wraps around enters the vacated end and is also copied to C.
- R9: Op 6 rotates left through carry and op 7 rotates right through carry. The incoming carry enters the vacated end, and the bit shifted out becomes the new C. When moving two positions, the bit shifted out in the first step is the bit that enters in the second.
- R10: N equals the result bit at the top of the selected width. Z is 1 exactly when the result is zero at the selected width.
- R11: The result and all flags are registered and appear one clock after the inputs are sampled. A synchronous active-high reset clears the result and all four flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | 32 | Value to shift or rotate |
| size_i | input | 2 | Operand width code |
| op_i | input | 3 | Operation code |
| by_two_i | input | 1 | 0 moves one position, 1 moves two |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Registered result, zero above the operand width |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The case hardest to reach is an arithmetic left shift by two in which only the second bit to enter the sign position differs from the sign. The top two bits then agree, and only the third bit from the top disagrees. Random word and long operands seldom produce this pattern. Every byte operand is therefore swept under every operation, distance and carry value, which covers all of these top-bit patterns at the smallest width. Fixed alternating and single-bit patterns cover them at the word and long widths. Garbage placed above the byte and word widths shows that those bits have no effect.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASL = 3'd2,
    OP_ASR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RCL = 3'd6,
    OP_RCR = 3'd7
  } shr_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LONG_ALT = 2'd3
  } shr_size_e;
endpackage

// File: rtl/shr_size_decode.sv
module shr_size_decode
  import shr_pkg::*;
#(
  parameter int BW = 8,
  parameter int DW = 4 * BW,
  localparam int IW = $clog2(DW)
) (
  input  shr_size_e     size_i,
  output logic [IW-1:0] msb_idx_o,
  output logic [DW-1:0] mask_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: msb_idx_o = IW'(BW - 1);
      SZ_WORD: msb_idx_o = IW'(2 * BW - 1);
      default: msb_idx_o = IW'(DW - 1);
    endcase
    mask_o = {DW{1'b1}} >> (IW'(DW - 1) - msb_idx_o);
  end
endmodule

// File: rtl/shr_step.sv
module shr_step
  import shr_pkg::*;
#(
  parameter int DW = 32,
  localparam int IW = $clog2(DW)
) (
  input  shr_op_e       op_i,
  input  logic [IW-1:0] msb_idx_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] val_i,
  input  logic          cin_i,
  input  logic          sign0_i,
  output logic [DW-1:0] val_o,
  output logic          cout_o,
  output logic          sign_chg_o
);
  logic top_b, low_b, go_left, fill_l, fill_r;

  always_comb begin
    top_b   = val_i[msb_idx_i];
    low_b   = val_i[0];
    go_left = (op_i == OP_LSL) || (op_i == OP_ASL) ||
              (op_i == OP_ROL) || (op_i == OP_RCL);
    unique case (op_i)
      OP_ROL:  fill_l = top_b;
      OP_RCL:  fill_l = cin_i;
      default: fill_l = 1'b0;
    endcase
    unique case (op_i)
      OP_ASR:  fill_r = top_b;
      OP_ROR:  fill_r = low_b;
      OP_RCR:  fill_r = cin_i;
      default: fill_r = 1'b0;
    endcase
    if (go_left) begin
      val_o  = ((val_i << 1) & mask_i) | DW'(fill_l);
      cout_o = top_b;
    end else begin
      val_o  = ((val_i & mask_i) >> 1) | (DW'(fill_r) << msb_idx_i);
      cout_o = low_b;
    end
    sign_chg_o = (op_i == OP_ASL) && (val_o[msb_idx_i] != sign0_i);
  end
endmodule

// File: rtl/shr_flags.sv
module shr_flags #(
  parameter int DW = 32,
  localparam int IW = $clog2(DW)
) (
  input  logic [DW-1:0] res_i,
  input  logic [IW-1:0] msb_idx_i,
  output logic          n_o,
  output logic          z_o
);
  always_comb begin
    n_o = res_i[msb_idx_i];
    z_o = (res_i == '0);
  end
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int BW = 8,
  parameter int MAX_STEP = 2,
  localparam int DW = 4 * BW,
  localparam int IW = $clog2(DW),
  localparam int CW = $clog2(MAX_STEP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   operand_i,
  input  logic [1:0]    size_i,
  input  logic [2:0]    op_i,
  input  logic          by_two_i,
  input  logic          carry_i,
  output logic [31:0]   result_o,
  output logic          n_o,
  output logic          z_o,
  output logic          v_o,
  output logic          c_o
);
  shr_op_e   op;
  shr_size_e sz;
  logic [IW-1:0] msb_idx;
  logic [DW-1:0] mask, opnd_m;
  logic [CW-1:0] amount;

  logic [MAX_STEP:0][DW-1:0] st_val;
  logic [MAX_STEP:0]         st_c;
  logic [MAX_STEP:0]         st_v;

  logic n_d, z_d;

  assign op     = shr_op_e'(op_i);
  assign sz     = shr_size_e'(size_i);
  assign amount = by_two_i ? CW'(MAX_STEP) : CW'(1);

  shr_size_decode #(.BW(BW), .DW(DW)) u_size (
    .size_i   (sz),
    .msb_idx_o(msb_idx),
    .mask_o   (mask)
  );

  assign opnd_m    = DW'(operand_i) & mask;
  assign st_val[0] = opnd_m;
  assign st_c[0]   = carry_i;
  assign st_v[0]   = 1'b0;

  for (genvar g = 0; g < MAX_STEP; g++) begin : g_stage
    logic [DW-1:0] s_val;
    logic          s_c, s_chg, s_en;
    shr_step #(.DW(DW)) u_step (
      .op_i      (op),
      .msb_idx_i (msb_idx),
      .mask_i    (mask),
      .val_i     (st_val[g]),
      .cin_i     (st_c[g]),
      .sign0_i   (opnd_m[msb_idx]),
      .val_o     (s_val),
      .cout_o    (s_c),
      .sign_chg_o(s_chg)
    );
    assign s_en        = (CW'(g) < amount);
    assign st_val[g+1] = s_en ? s_val : st_val[g];
    assign st_c[g+1]   = s_en ? s_c : st_c[g];
    assign st_v[g+1]   = st_v[g] | (s_en & s_chg);
  end

  shr_flags #(.DW(DW)) u_flags (
    .res_i    (st_val[MAX_STEP]),
    .msb_idx_i(msb_idx),
    .n_o      (n_d),
    .z_o      (z_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      n_o      <= 1'b0;
      z_o      <= 1'b0;
      v_o      <= 1'b0;
      c_o      <= 1'b0;
    end else begin
      result_o <= 32'(st_val[MAX_STEP]);
      n_o      <= n_d;
      z_o      <= z_d;
      v_o      <= st_v[MAX_STEP];
      c_o      <= st_c[MAX_STEP];
    end
  end

  p_upper_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (size_i == SZ_BYTE) |=> (result_o[31:BW] == '0));
  p_v_only_asl_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i != OP_ASL) |=> !v_o);
  p_rcl_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RCL && !by_two_i) |=> (result_o[0] == $past(carry_i)));
  p_lsl_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LSL && size_i == SZ_LONG && !by_two_i) |=> (c_o == $past(operand_i[31])));
  p_asr_sign_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ASR && size_i == SZ_LONG) |=> (result_o[31] == $past(operand_i[31])));
  p_zero_not_neg_r10: assert property (@(posedge clk) disable iff (rst)
    z_o |-> !n_o);
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !n_o && !z_o && !v_o && !c_o));
endmodule

// File: tb/shr_unit_test.sv
module shr_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand_i = 32'hDEAD_BEEF;
  logic [1:0]  size_i = 2'd2;
  logic [2:0]  op_i = 3'd4;
  logic        by_two_i = 1'b1;
  logic        carry_i = 1'b1;
  logic [31:0] result_o;
  logic        n_o, z_o, v_o, c_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  shr_unit uut (
    .clk(clk), .rst(rst), .operand_i(operand_i), .size_i(size_i), .op_i(op_i),
    .by_two_i(by_two_i), .carry_i(carry_i), .result_o(result_o),
    .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
  );

  function automatic logic [31:0] next_lfsr(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      3: return "R5";
      4, 5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [31:0] x_in, input int w, input int op, input int k,
                       input logic cin, output logic [31:0] r, output logic c, output logic v);
    logic [63:0] mk, mk1, x, y, t, t2, top, tm;
    logic s;
    mk  = (64'd1 << w) - 1;
    mk1 = (64'd1 << (w + 1)) - 1;
    x   = {32'd0, x_in} & mk;
    s   = x[w-1];
    v   = 1'b0;
    y   = '0;
    c   = 1'b0;
    case (op)
      0, 2: begin y = (x << k) & mk; c = x[w-k]; end
      1: begin y = x >> k; c = x[k-1]; end
      3: begin y = (x >> k) | (s ? (mk & ~(mk >> k)) : 64'd0); c = x[k-1]; end
      4: begin y = ((x << k) | (x >> (w - k))) & mk; c = y[0]; end
      5: begin y = ((x >> k) | (x << (w - k))) & mk; c = y[w-1]; end
      6: begin
        t = x | ({63'd0, cin} << w);
        t2 = ((t << k) | (t >> (w + 1 - k))) & mk1;
        y = t2 & mk; c = t2[w];
      end
      default: begin
        t = x | ({63'd0, cin} << w);
        t2 = ((t >> k) | (t << (w + 1 - k))) & mk1;
        y = t2 & mk; c = t2[w];
      end
    endcase
    if (op == 2) begin
      tm  = (64'd1 << (k + 1)) - 1;
      top = (x >> (w - 1 - k)) & tm;
      v   = !(top == 64'd0 || top == tm);
    end
    r = y[31:0];
  endtask

  task automatic run_one(input logic [31:0] x, input int szc, input int op, input bit two,
                         input logic cin);
    int w, k;
    logic [31:0] er;
    logic ec, ev, en, ez;
    string tg;
    w = (szc == 0) ? 8 : (szc == 1) ? 16 : 32;
    k = two ? 2 : 1;
    model(x, w, op, k, cin, er, ec, ev);
    en = er[w-1];
    ez = (er == 32'd0);
    operand_i = x; size_i = 2'(szc); op_i = 3'(op); by_two_i = two; carry_i = cin;
    @(posedge clk);
    @(negedge clk);
    tg = two ? {op_tag(op), "/R2"} : op_tag(op);
    total++;
    if (result_o !== er || c_o !== ec) begin
      bad++;
      $display("FAIL %s op=%0d size=%0d x=%h cin=%b: actual r=%h c=%b expected r=%h c=%b",
               tg, op, szc, x, cin, result_o, c_o, er, ec);
    end
    total++;
    if (v_o !== ev) begin
      bad++;
      $display("FAIL %s op=%0d size=%0d x=%h: actual v=%b expected v=%b",
               (op == 2) ? "R6" : "R7", op, szc, x, v_o, ev);
    end
    total++;
    if (n_o !== en || z_o !== ez) begin
      bad++;
      $display("FAIL R10 op=%0d size=%0d x=%h: actual n=%b z=%b expected n=%b z=%b",
               op, szc, x, n_o, z_o, en, ez);
    end
    if (w < 32) begin
      total++;
      if (result_o[31:16] !== 16'd0 || (w == 8 && result_o[15:8] !== 8'd0)) begin
        bad++;
        $display("FAIL R1 size=%0d: actual upper r=%h expected upper bits zero", szc, result_o);
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] corners [6];
    corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8000_8080; corners[3] = 32'h4000_4040;
    corners[4] = 32'h5555_5555; corners[5] = 32'hAAAA_AAAA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset clears outputs although inputs are active
    total++;
    if (result_o !== 32'd0 || {n_o, z_o, v_o, c_o} !== 4'b0000) begin
      bad++;
      $display("FAIL R11: actual r=%h nzvc=%b%b%b%b expected r=0 nzvc=0000",
               result_o, n_o, z_o, v_o, c_o);
    end
    rst = 1'b0;
    // R1 byte sweep: every operand, upper bits filled with garbage
    for (int op = 0; op < 8; op++)
      for (int tw = 0; tw < 2; tw++)
        for (int ci = 0; ci < 2; ci++)
          for (int xv = 0; xv < 256; xv++) begin
            lfsr = next_lfsr(lfsr);
            run_one({lfsr[31:8], 8'(xv)}, 0, op, bit'(tw), 1'(ci));
          end
    // word, long and alternate long code (R1)
    for (int szc = 1; szc < 4; szc++)
      for (int op = 0; op < 8; op++)
        for (int tw = 0; tw < 2; tw++)
          for (int ci = 0; ci < 2; ci++)
            for (int i = 0; i < 30; i++) begin
              lfsr = next_lfsr(lfsr);
              run_one((i < 6) ? corners[i] : lfsr, szc, op, bit'(tw), 1'(ci));
            end
    // R11: reset mid-run clears registered state
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    total++;
    if (result_o !== 32'd0 || {n_o, z_o, v_o, c_o} !== 4'b0000) begin
      bad++;
      $display("FAIL R11: actual r=%h nzvc=%b%b%b%b expected r=0 nzvc=0000",
               result_o, n_o, z_o, v_o, c_o);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule